// File: doc/BRIEF.md
# Disc Track Host Transfer Sequencer

This block is the host-side controller for one track of a rotating, clock-driven bit store. It runs on a single fast system clock. The track's write shift clock, read shift clock, once-per-turn origin pulse and read data line are all brought into that clock domain through synchronisers, and their edges are detected there. A position counter follows the angle of the disc. The origin pulse clears it, and each falling edge of the write shift clock advances it by one.

A command names the direction, a start position, a length, and, for a write, a parallel word of bits that goes out LSB first. A write puts bit 0 on the data line as soon as the command is taken. It raises write enable at the write shift fall where the counter equals the start position. It moves to the next bit on each later fall, and drops enable at the first write shift rise after the fall that presented the last bit. A read waits for the same positional match. It then lets a fixed number of read shift falls pass, to cover the track's two-bit pipeline, and captures the following falls into a shift register. A one-cycle done pulse marks the end of each transfer.

Top module: `disc_track_seq`

## Requirements
- R1: The position counter is cleared by a rising edge of `origin_in` and increments by one on every falling edge of `wshift_in`. The write enable timing of R3 is measured against this count.
- R2: While `rst` is high and after reset, `wr_en`, `data_wr`, `rd_bits` and `done` are all 0.
- R3: After a write command, `wr_en` rises on the `wshift_in` falling edge at which the counter, before its increment, equals `cmd_start`. It is high no later than 3 system clocks after that edge reaches the input.
- R4: From the cycle after a write command is taken until enable rises, `data_wr` carries bit 0 of `cmd_word`. The j-th falling edge after the enable edge puts bit j on `data_wr`, LSB first.
- R5: `wr_en` falls, and `data_wr` returns to 0, on the first `wshift_in` rising edge after the falling edge that presented bit `cmd_len`-1.
- R6: Every completed transfer gives exactly one `done` pulse, one system clock wide.
- R7: A read command (`cmd_write`=0) clears `rd_bits`. After the matching `wshift_in` fall, the next READ_LAT (default 2) falling edges of `rshift_in` are skipped. The following `cmd_len` falls store `rd_line_in` into `rd_bits` bits 0 upward, and higher bits stay 0.
- R8: A write leaves `rd_bits` unchanged, whatever `rshift_in` and `rd_line_in` do during it.
- R9: A command that arrives while a transfer is pending or running is ignored. A command with `cmd_len` of 0 or greater than DATA_W is also ignored: no enable, no data, no done.
- R10: Without an origin pulse, the counter goes from TRACK_BITS-1 back to 0, so a start position behind the current one is reached after the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wshift_in | input | 1 | Track write shift clock (asynchronous) |
| rshift_in | input | 1 | Track read shift clock (asynchronous) |
| origin_in | input | 1 | Once-per-revolution origin pulse (asynchronous) |
| rd_line_in | input | 1 | Track read data line (asynchronous) |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_start | input | POS_W | Angular start position |
| cmd_len | input | LEN_W | Number of bits, 1 to DATA_W |
| cmd_word | input | DATA_W | Bits to write, bit 0 first |
| data_wr | output | 1 | Data write line to the track |
| wr_en | output | 1 | Write enable to the track |
| rd_bits | output | DATA_W | Captured read bits, bit 0 first captured |
| done | output | 1 | One-cycle pulse at end of a transfer |

## Verification
A vector table runs writes with a mid-revolution start, a start at position 0 on the first fall after origin, a start on the last position so that the bits run across the wrap, and a full DATA_W-bit word. Between them, these cases show up an off-by-one in the position match, a missing early first bit, and a tail that drops enable too soon. Reads drive 1 on the skipped read shift periods and a distinct pattern on the captured ones, so a wrong latency count shows as a shifted value. A second, shorter read exposes a capture register that was not cleared. Further directed tests send zero-length and oversized commands, a command while busy, a write with the read line toggling, and a start position that can only be reached through the counter wrap.

// File: rtl/disc_seq_pkg.sv
package disc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WARM,
        ST_WRUN,
        ST_WTAIL,
        ST_RARM,
        ST_RSKIP,
        ST_RCAP
    } seq_state_e;

    // Synchronised track events consumed by the sequencer.
    typedef struct packed {
        logic wfall;
        logic wrise;
        logic rfall;
        logic rdat;
    } trk_evt_t;

    function automatic logic is_write_state(seq_state_e s);
        return (s == ST_WARM) || (s == ST_WRUN) || (s == ST_WTAIL);
    endfunction

endpackage

// File: rtl/dts_sync.sv
module dts_sync #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/dts_edge_det.sv
module dts_edge_det #(
    parameter int             N        = 4,
    parameter logic [N-1:0]   RISE_SEL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] ev
);
    logic [N-1:0] prv;

    always_ff @(posedge clk) begin
        if (rst) prv <= '0;
        else     prv <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_ch
        if (RISE_SEL[i]) begin : g_rise
            assign ev[i] = lvl[i] & ~prv[i];
        end else begin : g_fall
            assign ev[i] = ~lvl[i] & prv[i];
        end
    end
endmodule

// File: rtl/dts_pos_counter.sv
module dts_pos_counter #(
    parameter int TRACK_BITS = 100000,
    localparam int POS_W     = $clog2(TRACK_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             org_i,
    input  logic             wfall_i,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] LAST = POS_W'(TRACK_BITS - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)          pos_q <= '0;
        else if (org_i)   pos_q <= '0;
        else if (wfall_i) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end

    assign pos_o = pos_q;

    // R1: an origin edge always leaves the counter at zero
    p_origin_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(org_i) |-> (pos_q == '0));

    // R10: counter never leaves the track range
    p_pos_range_r10: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST);
endmodule

// File: rtl/dts_xfer_fsm.sv
module dts_xfer_fsm
    import disc_seq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int POS_W    = 17,
    parameter int READ_LAT = 2,
    localparam int LEN_W   = $clog2(DATA_W + 1),
    localparam int IDX_W   = $clog2(DATA_W),
    localparam int SKIP_W  = (READ_LAT > 1) ? $clog2(READ_LAT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  trk_evt_t          evt_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [POS_W-1:0]  cmd_start,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_word,
    output logic              data_wr,
    output logic              wr_en,
    output logic [DATA_W-1:0] rd_bits,
    output logic              done
);
    localparam logic [LEN_W-1:0]  LEN_MAX  = LEN_W'(DATA_W);
    localparam logic [SKIP_W-1:0] SKIP_END = SKIP_W'((READ_LAT > 0) ? READ_LAT - 1 : 0);

    seq_state_e        state_q;
    logic [POS_W-1:0]  start_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] word_q;
    logic [LEN_W-1:0]  idx_q;
    logic [SKIP_W-1:0] skip_q;
    logic              data_q;
    logic              en_q;
    logic [DATA_W-1:0] rd_q;
    logic              done_q;

    logic             accept;
    logic             hit;
    logic [LEN_W-1:0] idx_nx;

    assign accept = cmd_valid && (state_q == ST_IDLE) &&
                    (cmd_len != '0) && (cmd_len <= LEN_MAX);
    assign hit    = evt_i.wfall && (pos_i == start_q);
    assign idx_nx = idx_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            len_q   <= '0;
            word_q  <= '0;
            idx_q   <= '0;
            skip_q  <= '0;
            data_q  <= 1'b0;
            en_q    <= 1'b0;
            rd_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        start_q <= cmd_start;
                        len_q   <= cmd_len;
                        word_q  <= cmd_word;
                        idx_q   <= '0;
                        if (cmd_write) begin
                            data_q  <= cmd_word[0];
                            state_q <= ST_WARM;
                        end else begin
                            rd_q    <= '0;
                            state_q <= ST_RARM;
                        end
                    end
                end
                ST_WARM: begin
                    if (hit) begin
                        en_q    <= 1'b1;
                        state_q <= (len_q == LEN_W'(1)) ? ST_WTAIL : ST_WRUN;
                    end
                end
                ST_WRUN: begin
                    if (evt_i.wfall) begin
                        idx_q  <= idx_nx;
                        data_q <= word_q[idx_nx[IDX_W-1:0]];
                        if (idx_nx == len_q - 1'b1) state_q <= ST_WTAIL;
                    end
                end
                ST_WTAIL: begin
                    if (evt_i.wrise) begin
                        en_q    <= 1'b0;
                        data_q  <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_RARM: begin
                    if (hit) begin
                        skip_q  <= '0;
                        state_q <= (READ_LAT == 0) ? ST_RCAP : ST_RSKIP;
                    end
                end
                ST_RSKIP: begin
                    if (evt_i.rfall) begin
                        skip_q <= skip_q + 1'b1;
                        if (skip_q == SKIP_END) state_q <= ST_RCAP;
                    end
                end
                ST_RCAP: begin
                    if (evt_i.rfall) begin
                        rd_q[idx_q[IDX_W-1:0]] <= evt_i.rdat;
                        idx_q <= idx_nx;
                        if (idx_nx == len_q) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign data_wr = data_q;
    assign wr_en   = en_q;
    assign rd_bits = rd_q;
    assign done    = done_q;

    // R6: done is never wider than one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R3: enable only starts on a synchronised write shift fall
    p_en_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(evt_i.wfall));

    // R5: enable only ends on a synchronised write shift rise
    p_en_off_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(en_q) |-> $past(evt_i.wrise));

    // R4: while enabled, data moves only on write shift falls
    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (en_q && $past(en_q) && !$past(evt_i.wfall)) |-> $stable(data_q));

    // R8: captured bits are untouched throughout a write
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (is_write_state(state_q) && $past(is_write_state(state_q))) |-> $stable(rd_q));
endmodule

// File: rtl/disc_track_seq.sv
module disc_track_seq
    import disc_seq_pkg::*;
#(
    parameter int  TRACK_BITS  = 100000,
    parameter int  DATA_W      = 32,
    parameter int  SYNC_STAGES = 2,
    parameter int  READ_LAT    = 2,
    localparam int POS_W       = $clog2(TRACK_BITS),
    localparam int LEN_W       = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wshift_in,
    input  logic              rshift_in,
    input  logic              origin_in,
    input  logic              rd_line_in,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [POS_W-1:0]  cmd_start,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_word,
    output logic              data_wr,
    output logic              wr_en,
    output logic [DATA_W-1:0] rd_bits,
    output logic              done
);
    // Synchronised levels: {rd_line, origin, rshift, wshift}
    logic [3:0] lvl;
    // Events: [0] wshift fall, [1] wshift rise, [2] rshift fall, [3] origin rise
    logic [3:0] ev;
    logic [POS_W-1:0] pos;
    trk_evt_t evt;

    dts_sync #(.WIDTH(4), .DEPTH(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({rd_line_in, origin_in, rshift_in, wshift_in}),
        .q   (lvl)
    );

    dts_edge_det #(.N(4), .RISE_SEL(4'b1010)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl ({lvl[2], lvl[1], lvl[0], lvl[0]}),
        .ev  (ev)
    );

    dts_pos_counter #(.TRACK_BITS(TRACK_BITS)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .org_i   (ev[3]),
        .wfall_i (ev[0]),
        .pos_o   (pos)
    );

    assign evt = '{wfall: ev[0], wrise: ev[1], rfall: ev[2], rdat: lvl[3]};

    dts_xfer_fsm #(.DATA_W(DATA_W), .POS_W(POS_W), .READ_LAT(READ_LAT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .pos_i     (pos),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_start (cmd_start),
        .cmd_len   (cmd_len),
        .cmd_word  (cmd_word),
        .data_wr   (data_wr),
        .wr_en     (wr_en),
        .rd_bits   (rd_bits),
        .done      (done)
    );
endmodule

// File: tb/tb_disc_track_seq.sv
module tb_disc_track_seq;
    localparam int TB   = 20;
    localparam int DW   = 32;
    localparam int RLAT = 2;
    localparam int PW   = $clog2(TB);
    localparam int LW   = $clog2(DW + 1);

    typedef struct packed {
        logic [7:0]  start;
        logic [7:0]  len;
        logic [31:0] word;
    } wvec_t;

    localparam wvec_t WVECS [4] = '{
        '{8'd3,  8'd5,  32'h0000_0013},
        '{8'd0,  8'd1,  32'h0000_0001},
        '{8'd19, 8'd4,  32'h0000_000A},
        '{8'd5,  8'd32, 32'hC3A5_96F1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wshift_in = 1'b1, rshift_in = 1'b1, origin_in = 1'b0, rd_line_in = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [PW-1:0] cmd_start = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [DW-1:0] cmd_word = '0;
    logic data_wr, wr_en, done;
    logic [DW-1:0] rd_bits;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    int bpos = 0;
    logic en_at3;

    always #2.5 clk = ~clk;

    disc_track_seq #(.TRACK_BITS(TB), .DATA_W(DW), .SYNC_STAGES(2), .READ_LAT(RLAT)) dut (
        .clk(clk), .rst(rst), .wshift_in(wshift_in), .rshift_in(rshift_in),
        .origin_in(origin_in), .rd_line_in(rd_line_in), .cmd_valid(cmd_valid),
        .cmd_write(cmd_write), .cmd_start(cmd_start), .cmd_len(cmd_len),
        .cmd_word(cmd_word), .data_wr(data_wr), .wr_en(wr_en),
        .rd_bits(rd_bits), .done(done)
    );

    always @(negedge clk) if (done) done_cnt++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic fall_half(input logic rd_val);
        wshift_in = 1'b0; rshift_in = 1'b0; rd_line_in = rd_val;
        repeat (3) @(negedge clk);
        en_at3 = wr_en;
        @(negedge clk);
        bpos = (bpos + 1) % TB;
    endtask

    task automatic rise_half();
        wshift_in = 1'b1; rshift_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic origin_pulse();
        origin_in = 1'b1; repeat (4) @(negedge clk);
        origin_in = 1'b0; repeat (4) @(negedge clk);
        bpos = 0;
    endtask

    task automatic issue_cmd(input logic wr, input int start, input int len, input logic [DW-1:0] w);
        cmd_valid = 1'b1; cmd_write = wr; cmd_start = PW'(start);
        cmd_len = LW'(len); cmd_word = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_write(input int start, input int len, input logic [DW-1:0] w,
                            input bit do_org, input bit extra, input string nm);
        bit armed, active, finished, hitp;
        int j, d0;
        logic [DW-1:0] rd_before;
        if (do_org) origin_pulse();
        issue_cmd(1'b1, start, len, w);
        if (extra) issue_cmd(1'b1, (start + 2) % TB, 1, ~w);
        chk({nm, " R4 early first bit"}, 64'(data_wr), 64'(w[0]));
        chk({nm, " R3 enable low before match"}, 64'(wr_en), 64'd0);
        rd_before = rd_bits;
        armed = 1; active = 0; finished = 0; j = 0; d0 = done_cnt;
        for (int p = 0; p < 3 * TB && !finished; p++) begin
            hitp = armed && (bpos == start);
            fall_half(p[0]);
            if (hitp) begin
                armed = 0; active = 1; j = 0;
                chk({nm, " R1 R3 enable within 3 clocks of match"}, 64'(en_at3), 64'd1);
            end else if (active) begin
                j++;
            end
            chk({nm, " R3 enable after fall"}, 64'(wr_en), 64'(active));
            chk({nm, " R4 data after fall"}, 64'(data_wr), 64'(active ? w[j] : w[0]));
            rise_half();
            if (active && j == len - 1) begin
                active = 0; finished = 1;
                chk({nm, " R5 enable dropped"}, 64'(wr_en), 64'd0);
                chk({nm, " R5 data cleared"}, 64'(data_wr), 64'd0);
                chk({nm, " R6 one done"}, 64'(done_cnt), 64'(d0 + 1));
            end else begin
                chk({nm, " R5 enable held"}, 64'(wr_en), 64'(active));
            end
        end
        chk({nm, " R3 transfer completed"}, 64'(finished), 64'd1);
        chk({nm, " R8 read bits kept"}, 64'(rd_bits), 64'(rd_before));
    endtask

    task automatic do_read(input int start, input int len, input logic [DW-1:0] pat, input string nm);
        int d0, first, last;
        logic rv;
        origin_pulse();
        issue_cmd(1'b0, start, len, '0);
        chk({nm, " R7 cleared on accept"}, 64'(rd_bits), 64'd0);
        d0 = done_cnt;
        first = start + 1 + RLAT;
        last  = first + len - 1;
        for (int p = 0; p <= last; p++) begin
            rv = (p >= first) ? pat[p - first] : 1'b1;
            fall_half(rv);
            rise_half();
        end
        chk({nm, " R7 captured bits"}, 64'(rd_bits), 64'(pat & ((DW'(1) << len) - 1)));
        chk({nm, " R6 one done"}, 64'(done_cnt), 64'(d0 + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        chk("R2 wr_en in reset", 64'(wr_en), 64'd0);
        chk("R2 data_wr in reset", 64'(data_wr), 64'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 wr_en after reset", 64'(wr_en), 64'd0);
        chk("R2 data_wr after reset", 64'(data_wr), 64'd0);
        chk("R2 rd_bits after reset", 64'(rd_bits), 64'd0);
        chk("R2 done after reset", 64'(done_cnt), 64'd0);

        for (int v = 0; v < 4; v++)
            do_write(int'(WVECS[v].start), int'(WVECS[v].len), WVECS[v].word, 1, 0, "vector");

        do_read(2, 4, 32'h6, "read a");
        do_read(1, 2, 32'h3, "read b");

        // R8: write with the read line and read shift toggling
        do_write(7, 3, 32'h5, 1, 0, "write over read");
        chk("R8 read bits after write", 64'(rd_bits), 64'h3);

        // R9: zero and oversized lengths are dropped
        d0 = done_cnt;
        issue_cmd(1'b1, 2, 0, '1);
        issue_cmd(1'b1, 2, DW + 1, '1);
        for (int p = 0; p < TB + 2; p++) begin
            fall_half(1'b0);
            chk("R9 no enable for bad length", 64'(wr_en), 64'd0);
            chk("R9 no data for bad length", 64'(data_wr), 64'd0);
            rise_half();
        end
        chk("R9 no done for bad length", 64'(done_cnt), 64'(d0));

        // R9: second command while first is armed is ignored
        do_write(10, 3, 32'h5, 1, 1, "busy");

        // R10: reach a position behind the counter by wrapping
        do_write((bpos + TB - 2) % TB, 2, 32'h2, 0, 0, "wrap R10");

        repeat (10) @(negedge clk);
        summary();
    end
endmodule